// File: doc/BRIEF.md
# Multi-channel sample transposing packer

This block sits between a parallel probe front end and a byte-wide FIFO toward a USB link. At every sample strobe it takes one snapshot of the probe lines. It keeps only the channels selected by an enable mask. For each kept channel it builds a word out of that channel's level at 16 successive strobes, so the output is a transpose of the input. The input is one time step across all channels. The output is one channel across 16 time steps.

When a group of 16 samples is complete, the words move into a send buffer. They then leave as bytes on a valid/ready interface: two bytes per enabled channel, lowest channel first. Capture of the next group runs while the buffer drains. If a group completes while the buffer still holds undelivered bytes, the new group is discarded and a sticky overflow flag is raised. A start pulse aligns the sample count and clears the flag. A stop pulse halts capture but lets the buffered group drain.

Top module: `chan_transpose_packer`

## Requirements
- R1: While and after reset, `outValid` and `overflow` are 0.
- R2: In a channel word, bit k is that channel's probe level at the k-th strobe of the group. Bit 0 is the earliest strobe. A 1 means high and a 0 means low.
- R3: Each channel word goes out as two bytes: bits 7:0 first, then bits 15:8.
- R4: Within a group, words go out for enabled channels only, in ascending channel index. Each new group starts again at the lowest enabled channel. Any mask is accepted, for example 3, 6, 9 or 16 channels, or a sparse mask.
- R5: The enable mask follows `chanMask` only while capture is stopped. Changing `chanMask` during capture has no effect on the bytes produced.
- R6: A start pulse resets the sample count, which discards any partial group. A strobe in the same cycle as the start pulse is not counted.
- R7: A byte moves only on a cycle where `outValid` and `outReady` are both 1. While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` holds its value.
- R8: If a group completes while bytes of the previous group are still undelivered, the new group is dropped and `overflow` becomes 1. `overflow` stays 1 until the next start pulse, which clears it.
- R9: Capture continues while a group is being sent. Groups that drain in time are delivered back to back with no loss and no overflow.
- R10: After a stop pulse, strobes are not captured, and a group already in the send buffer still drains completely.
- R11: With an all-zero enable mask, completed groups produce no bytes and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| captureStart | input | 1 | One-cycle pulse that starts (or restarts) capture and clears overflow |
| captureStop | input | 1 | One-cycle pulse that halts capture |
| chanMask | input | 16 | Channel enable mask, taken only while stopped |
| sampleStb | input | 1 | Sample strobe, one per sample instant |
| probeIn | input | 16 | Parallel probe levels |
| outReady | input | 1 | Downstream can take a byte |
| outData | output | 8 | Byte being offered |
| outValid | output | 1 | `outData` holds a byte to transfer |
| overflow | output | 1 | Sticky flag: a group was lost |

## Verification
The properties assume that `captureStart` and `captureStop` are single-cycle pulses that never occur together. They also assume that reset is applied once, at the beginning, and never again while bytes are pending. The bench drives every input on the falling clock edge, pulses start and stop in separate cycles, and holds the strobe low on those cycles except in the one test that checks a strobe coinciding with start. The readiness patterns used are always ready, every other cycle, one cycle in three, and never. The never-ready pattern is the one that forces the overflow case.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  parameter int NUM_CH  = 16;
  parameter int SAMPLES = 16;

  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W  = $clog2(SAMPLES);
  localparam int BYTES  = SAMPLES / 8;
  localparam int BSEL_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic              shiftEn;
    logic              loadBuf;
    logic [CH_W-1:0]   curCh;
    logic [BSEL_W-1:0] byteSel;
  } dpCtrl_t;
endpackage

// File: rtl/tpk_datapath.sv
module tpk_datapath
  import tpk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] probeIn,
  input  dpCtrl_t           dpCtrl,
  output logic [7:0]        outData
);
  logic [SAMPLES-1:0] capWord [NUM_CH];
  logic [SAMPLES-1:0] sendBuf [NUM_CH];
  logic [SAMPLES-1:0] selWord;

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_lane
      logic [SAMPLES-1:0] shifted;
      // newest sample enters at the top, so bit 0 ends up earliest
      assign shifted = {probeIn[ch], capWord[ch][SAMPLES-1:1]};

      always_ff @(posedge clk) begin
        if (!rstN) begin
          capWord[ch] <= '0;
          sendBuf[ch] <= '0;
        end else begin
          if (dpCtrl.shiftEn) capWord[ch] <= shifted;
          if (dpCtrl.loadBuf) sendBuf[ch] <= shifted;
        end
      end
    end
  endgenerate

  assign selWord = sendBuf[dpCtrl.curCh];
  assign outData = selWord[{dpCtrl.byteSel, 3'b000} +: 8];
endmodule

// File: rtl/tpk_ctrl.sv
module tpk_ctrl
  import tpk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureStart,
  input  logic              captureStop,
  input  logic              sampleStb,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              outReady,
  output logic              outValid,
  output logic              overflow,
  output logic              capturing,
  output dpCtrl_t           dpCtrl
);
  logic              running;
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] sendMask;
  logic [CNT_W-1:0]  sampCnt;
  logic              busy;
  logic [CH_W-1:0]   curCh;
  logic [BSEL_W-1:0] byteSel;

  logic              firstFound, nextFound;
  logic [CH_W-1:0]   firstIdx, nextIdx;
  logic              shiftEn, groupDone, fire, lastByte, sendFree;
  logic              loadBuf, dropGroup;

  // lowest enabled channel, and lowest enabled channel above curCh
  always_comb begin
    firstFound = 1'b0;
    firstIdx   = '0;
    nextFound  = 1'b0;
    nextIdx    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (maskReg[i]) begin
        firstFound = 1'b1;
        firstIdx   = CH_W'(i);
      end
      if (sendMask[i] && (i > int'(curCh))) begin
        nextFound = 1'b1;
        nextIdx   = CH_W'(i);
      end
    end
  end

  assign shiftEn   = running & sampleStb & ~captureStart & ~captureStop;
  assign groupDone = shiftEn & (sampCnt == CNT_W'(SAMPLES - 1));
  assign fire      = busy & outReady;
  assign lastByte  = (byteSel == BSEL_W'(BYTES - 1));
  assign sendFree  = ~busy | (fire & lastByte & ~nextFound);
  assign loadBuf   = groupDone & firstFound & sendFree;
  assign dropGroup = groupDone & firstFound & ~sendFree;

  // capture side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      sampCnt  <= '0;
      maskReg  <= '0;
      overflow <= 1'b0;
    end else begin
      if (!running) maskReg <= chanMask;
      if (captureStart) begin
        running  <= 1'b1;
        sampCnt  <= '0;
        overflow <= 1'b0;
      end else if (captureStop) begin
        running <= 1'b0;
        sampCnt <= '0;
      end else begin
        if (shiftEn) sampCnt <= sampCnt + 1'b1;
        if (dropGroup) overflow <= 1'b1;
      end
    end
  end

  // send side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      curCh    <= '0;
      byteSel  <= '0;
      sendMask <= '0;
    end else if (loadBuf) begin
      busy     <= 1'b1;
      curCh    <= firstIdx;
      byteSel  <= '0;
      sendMask <= maskReg;
    end else if (fire) begin
      if (!lastByte) begin
        byteSel <= byteSel + 1'b1;
      end else if (nextFound) begin
        curCh   <= nextIdx;
        byteSel <= '0;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign outValid       = busy;
  assign capturing      = running;
  assign dpCtrl.shiftEn = shiftEn;
  assign dpCtrl.loadBuf = loadBuf;
  assign dpCtrl.curCh   = curCh;
  assign dpCtrl.byteSel = byteSel;
endmodule

// File: rtl/chan_transpose_packer.sv
module chan_transpose_packer
  import tpk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureStart,
  input  logic              captureStop,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              sampleStb,
  input  logic [NUM_CH-1:0] probeIn,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outValid,
  output logic              overflow
);
  dpCtrl_t dpCtrl;
  logic    capturing;

  tpk_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .captureStart (captureStart),
    .captureStop  (captureStop),
    .sampleStb    (sampleStb),
    .chanMask     (chanMask),
    .outReady     (outReady),
    .outValid     (outValid),
    .overflow     (overflow),
    .capturing    (capturing),
    .dpCtrl       (dpCtrl)
  );

  tpk_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .probeIn (probeIn),
    .dpCtrl  (dpCtrl),
    .outData (outData)
  );
endmodule

// File: rtl/tpk_checker.sv
module tpk_checker (
  input logic       clk,
  input logic       rstN,
  input logic       captureStart,
  input logic       capturing,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       overflow
);
  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !captureStart |=> overflow);

  a_r8_cleared_by_start: assert property (@(posedge clk) disable iff (!rstN)
    captureStart |=> !overflow);

  a_r10_no_overflow_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !capturing && !captureStart |=> !$rose(overflow));
endmodule

bind chan_transpose_packer tpk_checker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .captureStart (captureStart),
  .capturing    (capturing),
  .outValid     (outValid),
  .outReady     (outReady),
  .outData      (outData),
  .overflow     (overflow)
);

// File: tb/chan_transpose_packer_tb_top.sv
module chan_transpose_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  // {readyMode[1:0], mask[15:0], seed[15:0]}
  localparam logic [33:0] VEC [5] = '{
    {2'd0, 16'h0007, 16'hA5C3},
    {2'd1, 16'h003F, 16'h1E2D},
    {2'd2, 16'h01FF, 16'h7B01},
    {2'd0, 16'hFFFF, 16'hC0DE},
    {2'd1, 16'h8421, 16'h3355}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        captureStart = 1'b0;
  logic        captureStop = 1'b0;
  logic [15:0] chanMask = '0;
  logic        sampleStb = 1'b0;
  logic [15:0] probeIn = '0;
  logic        outReady = 1'b0;
  logic [7:0]  outData;
  logic        outValid;
  logic        overflow;

  int total = 0;
  int bad = 0;
  int readyMode = 0;
  int cyc = 0;
  int stableErr = 0;
  bit holdPend = 0;
  logic [7:0] holdData;
  bit done = 0;

  logic [7:0]  rxBuf [256];
  int          rxCnt = 0;
  logic [7:0]  expBuf [256];
  int          expCnt = 0;
  logic [15:0] smp [128];
  int          smpCnt = 0;

  chan_transpose_packer dut_i (
    .clk(clk), .rstN(rstN), .captureStart(captureStart), .captureStop(captureStop),
    .chanMask(chanMask), .sampleStb(sampleStb), .probeIn(probeIn), .outReady(outReady),
    .outData(outData), .outValid(outValid), .overflow(overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // receiver: choose readiness, then record the transfer that happens at the next rise
  always @(negedge clk) begin
    cyc++;
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = cyc[0];
      2: outReady = (cyc % 3 == 0);
      default: outReady = 1'b0;
    endcase
    if (holdPend && (!outValid || outData != holdData)) stableErr++;
    holdPend = outValid && !outReady;
    holdData = outData;
    if (outValid && outReady) begin
      if (rxCnt < 256) rxBuf[rxCnt] = outData;
      rxCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] gen(input logic [15:0] seed, input int k);
    logic [15:0] r;
    int s;
    s = k % 16;
    r = (seed << s) | (seed >> (16 - s));
    return r ^ 16'(k * 16'h0101);
  endfunction

  task automatic doSample(input logic [15:0] v, input bit rec, input int gap);
    probeIn = v;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    if (rec) begin
      smp[smpCnt] = v;
      smpCnt++;
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulseStart();
    captureStart = 1'b1;
    @(negedge clk);
    captureStart = 1'b0;
  endtask

  task automatic pulseStop();
    captureStop = 1'b1;
    @(negedge clk);
    captureStop = 1'b0;
  endtask

  task automatic clearStreams();
    rxCnt = 0;
    expCnt = 0;
    smpCnt = 0;
  endtask

  // expected stream from the requirements: per group, ascending channels, low byte first
  task automatic buildExp(input logic [15:0] mask);
    logic [15:0] w;
    for (int g = 0; g < smpCnt / 16; g++) begin
      for (int ch = 0; ch < 16; ch++) begin
        if (mask[ch]) begin
          for (int k = 0; k < 16; k++) w[k] = smp[g * 16 + k][ch];
          expBuf[expCnt]     = w[7:0];
          expBuf[expCnt + 1] = w[15:8];
          expCnt += 2;
        end
      end
    end
  endtask

  task automatic checkStream(input string tag);
    int mis;
    mis = -1;
    check(rxCnt == expCnt, tag, "byte count", rxCnt, expCnt);
    for (int i = expCnt - 1; i >= 0; i--)
      if (i < rxCnt && rxBuf[i] != expBuf[i]) mis = i;
    if (mis >= 0) check(1'b0, tag, $sformatf("byte value at index %0d", mis), int'(rxBuf[mis]), int'(expBuf[mis]));
    else check(1'b1, tag, "byte values", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vMask, vSeed;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!outValid && !overflow, "R1", "valid/overflow during reset", {outValid, overflow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !overflow, "R1", "valid/overflow after reset", {outValid, overflow}, 0);

    // table of masks, patterns and readiness: R2 R3 R4 R7
    for (int v = 0; v < 5; v++) begin
      readyMode = int'(VEC[v][33:32]);
      vMask = VEC[v][31:16];
      vSeed = VEC[v][15:0];
      clearStreams();
      chanMask = vMask;
      @(negedge clk);
      pulseStart();
      for (int k = 0; k < 16; k++) doSample(gen(vSeed, k), 1'b1, 1);
      pulseStop();
      repeat (150) @(negedge clk);
      buildExp(vMask);
      checkStream($sformatf("R2 R3 R4 vector %0d", v));
    end

    // R5: mask change during capture has no effect
    readyMode = 0;
    clearStreams();
    chanMask = 16'h0003;
    @(negedge clk);
    pulseStart();
    chanMask = 16'hFFFF;
    for (int k = 0; k < 16; k++) doSample(gen(16'h9C31, k), 1'b1, 1);
    pulseStop();
    repeat (80) @(negedge clk);
    buildExp(16'h0003);
    checkStream("R5");

    // R6: restart discards partial group; strobe in start cycle not counted
    clearStreams();
    chanMask = 16'h0009;
    @(negedge clk);
    pulseStart();
    for (int k = 0; k < 5; k++) doSample(16'hFFFF, 1'b0, 1);
    captureStart = 1'b1;
    sampleStb = 1'b1;
    probeIn = 16'hFFFF;
    @(negedge clk);
    captureStart = 1'b0;
    sampleStb = 1'b0;
    for (int k = 0; k < 16; k++) doSample(gen(16'h5A3C, k), 1'b1, 1);
    pulseStop();
    repeat (60) @(negedge clk);
    buildExp(16'h0009);
    checkStream("R6");

    // R8: overflow when buffer not drained; dropped group; sticky; cleared by start
    clearStreams();
    readyMode = 3;
    chanMask = 16'hFFFF;
    @(negedge clk);
    pulseStart();
    for (int k = 0; k < 32; k++) doSample(gen(16'h6E17, k), (k < 16), 1);
    check(overflow == 1'b1, "R8", "overflow set", overflow, 1);
    pulseStop();
    readyMode = 0;
    repeat (100) @(negedge clk);
    buildExp(16'hFFFF);
    checkStream("R8 dropped group");
    check(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);
    pulseStart();
    check(overflow == 1'b0, "R8", "overflow cleared by start", overflow, 0);
    pulseStop();
    repeat (5) @(negedge clk);

    // R9 back to back groups; R10 strobes after stop ignored
    clearStreams();
    readyMode = 1;
    chanMask = 16'h0007;
    @(negedge clk);
    pulseStart();
    for (int k = 0; k < 48; k++) doSample(gen(16'h2B4D, k), 1'b1, 1);
    check(overflow == 1'b0, "R9", "no overflow", overflow, 0);
    pulseStop();
    for (int k = 0; k < 16; k++) doSample(gen(16'hF00F, k), 1'b0, 1);
    repeat (80) @(negedge clk);
    buildExp(16'h0007);
    checkStream("R9 R10");

    // R11: empty mask
    clearStreams();
    readyMode = 0;
    chanMask = 16'h0000;
    @(negedge clk);
    pulseStart();
    for (int k = 0; k < 32; k++) doSample(gen(16'h1234, k), 1'b0, 0);
    pulseStop();
    repeat (40) @(negedge clk);
    check(rxCnt == 0, "R11", "bytes with empty mask", rxCnt, 0);
    check(overflow == 1'b0, "R11", "overflow with empty mask", overflow, 0);

    // R7: data held while waiting
    check(stableErr == 0, "R7", "hold violations", stableErr, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule